// File: doc/BRIEF.md
# Serial EEPROM Target with Self-Timed Write

This block is a two-wire serial bus target that behaves as an 8192-byte non-volatile memory. It answers a 7-bit bus address formed from the fixed type code 1010 and three strap inputs. A host writes one byte with a two-byte word address. It reads one byte back by sending the word address, then a repeated START and a read request. After every committed write, the target runs an internal write cycle of `WR_CYCLES` system clocks. During that cycle it does not acknowledge its own address, so a host that arrives too early sees a NACK and must retry. Real parts need about 10 ms for this; simulation uses a short value.

SCL and SDA enter through a synchronizer and edge detector. The target drives the open-drain SDA line with `sda_oe_o`: a 1 pulls SDA low. The target never stretches SCL. Storage is an on-chip array of 32-bit words with byte lanes.

Control is one state machine. Its states are:
- `ST_IDLE`: the bus is free.
- `ST_DEV`: shifts in the address byte.
- `ST_DEV_ACK`: acknowledges the address byte.
- `ST_AHI` and `ST_AHI_ACK`: receive and acknowledge the high word-address byte.
- `ST_ALO` and `ST_ALO_ACK`: receive and acknowledge the low word-address byte.
- `ST_WDAT` and `ST_WDAT_ACK`: receive and acknowledge the data byte.
- `ST_RDAT`: shifts out the read byte.
- `ST_RDAT_ACK`: leaves SDA free for the host's acknowledge bit.
- `ST_IGNORE`: waits with SDA released.

Its transitions are:
- Any START goes to `ST_DEV`. Any STOP goes to `ST_IDLE`.
- A receive state moves on at the SCL fall after eight bits. Each `*_ACK` state moves on at the next SCL fall.
- `ST_DEV` goes to `ST_DEV_ACK` on a match while not busy. Otherwise it goes to `ST_IGNORE`.
- `ST_DEV_ACK` goes to `ST_RDAT` for a read and to `ST_AHI` for a write.
- `ST_WDAT_ACK` and `ST_RDAT_ACK` go to `ST_IGNORE`.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset, `sda_oe_o` is 0, the target is idle and no write cycle is running.
- R2: The target acknowledges only the address byte whose upper seven bits equal {1010, strap_i[2:0]}. Bit 0 of that byte is the direction: 0 means write, 1 means read. Any other address gets no acknowledge, and SDA stays released until the next START.
- R3: START, address with write, high address, low address, data byte, STOP stores the data byte at the 13-bit word address. Other bytes in the same 32-bit storage word keep their values.
- R4: The upper three bits of the high address byte are ignored. For example, high byte 0xE1 addresses the same byte as 0x01.
- R5: A random read returns the byte stored at the word address, most significant bit first. The host sends the word address with a write request, then a repeated START and the address byte with read. After the eighth bit, SDA is released for the host's acknowledge bit.
- R6: A STOP that ends a write holding a data byte starts an internal cycle of `WR_CYCLES` clocks. While that cycle runs, the target gives no acknowledge to its own address. After the cycle ends, it acknowledges again.
- R7: A write that ends with STOP after the address bytes stores nothing and starts no write cycle. It only sets the read pointer.
- R8: The target pulls SDA low only while SCL is low, and it samples SDA on the rising edge of SCL.
- R9: For every accepted byte, the target pulls SDA low during the ninth clock. It does not acknowledge any data byte after the first one in a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 3 | Address strap pins, low bits of the bus address |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases SDA |

## Verification
Several properties are checked on every cycle:
- SDA is only ever pulled low while the synchronized SCL is low.
- An acknowledge is only asserted after eight received bits.
- An address acknowledge never occurs while a write cycle runs.
- A new write cycle is never started on top of a running one.

The rest needs the bench's bus transactions. These cover:
- stored and returned byte values;
- that the high address bits are ignored;
- that neighbouring bytes in a storage word are preserved;
- that an address-only write leaves the target ready;
- the NACK-then-ACK retry pattern just before and just after the end of the write cycle.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK,
        ST_IGNORE
    } eep_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [SYNC_STAGES-1:0] scl_sr;
    logic [SYNC_STAGES-1:0] sda_sr;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
            sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_sr[SYNC_STAGES-1];
            sda_q  <= sda_sr[SYNC_STAGES-1];
        end
    end

    assign scl_o      = scl_sr[SYNC_STAGES-1];
    assign sda_o      = sda_sr[SYNC_STAGES-1];
    assign scl_rise_o = scl_o & ~scl_q;
    assign scl_fall_o = ~scl_o & scl_q;
    // SDA moving while SCL stays high marks a bus condition
    assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
    assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
    parameter int unsigned WR_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start_i) begin
            remain <= CW'(WR_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy_o = (remain != '0);

    AST_NO_RESTART_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o); // R6

endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_W = 13,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);

    localparam int WORD_AW = ADDR_W - LANE_W;
    localparam int WORDS   = 2 ** WORD_AW;
    localparam int WORD_W  = 8 * (2 ** LANE_W);

    logic [WORD_W-1:0] mem [WORDS];
    logic [WORD_W-1:0] rd_word;

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem[wr_addr_i[ADDR_W-1:LANE_W]][{wr_addr_i[LANE_W-1:0], 3'b000} +: 8] <= wr_data_i;
        end
    end

    assign rd_word   = mem[rd_addr_i[ADDR_W-1:LANE_W]];
    assign rd_data_o = rd_word[{rd_addr_i[LANE_W-1:0], 3'b000} +: 8];

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import i2c_eep_pkg::*;
#(
    parameter int unsigned WR_CYCLES   = 500000,
    parameter int          ADDR_W      = 13,
    parameter int          LANE_W      = 2,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o
);

    localparam int HI_W = ADDR_W - 8;

    eep_state_e        state, state_n;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              busy;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic [7:0]        tx;
    logic [HI_W-1:0]   addr_hi;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        wr_data;
    logic              wr_pend;
    logic              mem_we;
    logic [7:0]        rd_data;
    logic              byte_done;
    logic              dev_hit;
    logic              rx_state;

    i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) line_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    eep_wr_timer #(.WR_CYCLES(WR_CYCLES)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (mem_we),
        .busy_o  (busy)
    );

    eep_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) store_i (
        .clk       (clk),
        .wr_en_i   (mem_we),
        .wr_addr_i (ptr),
        .wr_data_i (wr_data),
        .rd_addr_i (ptr),
        .rd_data_o (rd_data)
    );

    assign byte_done = (bit_cnt == 4'd8);
    assign dev_hit   = (shreg[7:1] == {DEV_TYPE, strap_i}) && !busy;
    assign rx_state  = (state == ST_DEV) || (state == ST_AHI) || (state == ST_ALO) ||
                       (state == ST_WDAT) || (state == ST_RDAT);
    assign mem_we    = stop_det && wr_pend;

    // next-state logic
    always_comb begin
        state_n = state;
        if (stop_det) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_DEV;
        end else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_DEV:      if (scl_fall && byte_done) state_n = dev_hit ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK:  if (scl_fall) state_n = shreg[0] ? ST_RDAT : ST_AHI;
                ST_AHI:      if (scl_fall && byte_done) state_n = ST_AHI_ACK;
                ST_AHI_ACK:  if (scl_fall) state_n = ST_ALO;
                ST_ALO:      if (scl_fall && byte_done) state_n = ST_ALO_ACK;
                ST_ALO_ACK:  if (scl_fall) state_n = ST_WDAT;
                ST_WDAT:     if (scl_fall && byte_done) state_n = ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall) state_n = ST_IGNORE;
                ST_RDAT:     if (scl_fall && byte_done) state_n = ST_RDAT_ACK;
                ST_RDAT_ACK: if (scl_fall) state_n = ST_IGNORE;
                ST_IGNORE:   state_n = ST_IGNORE;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // bit counter and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            tx      <= '0;
            addr_hi <= '0;
            ptr     <= '0;
            wr_data <= '0;
            wr_pend <= 1'b0;
        end else begin
            if (state_n != state) begin
                bit_cnt <= '0;
            end else if (scl_rise && rx_state) begin
                bit_cnt <= bit_cnt + 1'b1;
            end

            if (scl_rise && rx_state && (state != ST_RDAT)) begin
                shreg <= {shreg[6:0], sda_s};
            end

            if (state == ST_AHI && state_n == ST_AHI_ACK) begin
                addr_hi <= shreg[HI_W-1:0];
            end
            if (state == ST_ALO && state_n == ST_ALO_ACK) begin
                ptr <= {addr_hi, shreg};
            end

            if (state == ST_DEV_ACK && state_n == ST_RDAT) begin
                tx <= rd_data;
            end else if (state == ST_RDAT && scl_fall && !byte_done) begin
                tx <= {tx[6:0], 1'b0};
            end

            if (start_det || stop_det) begin
                wr_pend <= 1'b0;
            end else if (state == ST_WDAT && state_n == ST_WDAT_ACK) begin
                wr_data <= shreg;
                wr_pend <= 1'b1;
            end
        end
    end

    // output logic
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: sda_oe_o = 1'b1;
            ST_RDAT:                                         sda_oe_o = ~tx[7];
            default:                                         sda_oe_o = 1'b0;
        endcase
    end

    AST_SDA_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s); // R8

    AST_ACK_AFTER_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) && (state inside {ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK}))
        |-> ($past(bit_cnt) == 4'd8)); // R9

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK) |-> !busy); // R6

    AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det)); // R7

endmodule

// File: tb/i2c_eeprom_slave_tb_top.sv
module i2c_eeprom_slave_tb_top;

    localparam int WR_CYC = 2000;
    localparam int Q      = 10;

    typedef struct {
        int    val;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic [2:0] strap = 3'b000;
    logic       sda_oe;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;
    int r8_viol = 0;
    exp_t exp_q[$];
    int   obs_q[$];

    assign sda_bus = !(m_low || sda_oe);

    always #2.5 clk = ~clk;

    i2c_eeprom_slave #(.WR_CYCLES(WR_CYC)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .strap_i  (strap),
        .sda_oe_o (sda_oe)
    );

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                exp_t e;
                int   o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                checks++;
                if (o != e.val) begin
                    errors++;
                    $display("FAIL %s: got %0h expected %0h", e.tag, o, e.val);
                end
            end
        end
    end

    // R8 line monitor: target must not start pulling SDA while SCL is high
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && sda_oe && !prev && scl) r8_viol++;
            prev = sda_oe;
        end
    end

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        m_low = !b; qwait();
        scl = 1'b1; qwait(); qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic get_bit(output logic b);
        m_low = 1'b0; qwait();
        scl = 1'b1; qwait();
        b = sda_bus; qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic bus_start();
        m_low = 1'b0; qwait();
        scl = 1'b1; qwait();
        m_low = 1'b1; qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; qwait();
        scl = 1'b1; qwait();
        m_low = 1'b0; qwait(); qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag,
                             output logic acked);
        logic a;
        exp_q.push_back('{val: exp_ack ? 0 : 1, tag: tag});
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(a);
        obs_q.push_back(int'(a));
        acked = !a;
    endtask

    task automatic recv_byte(input logic [7:0] exp, input string tag);
        logic [7:0] d;
        logic       b;
        exp_q.push_back('{val: int'(exp), tag: tag});
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(1'b1);
        obs_q.push_back(int'(d));
    endtask

    task automatic eep_write(input logic [6:0] dev, input logic [15:0] addr, input logic [7:0] data,
                             input logic exp_ack, input string tag);
        logic ok;
        bus_start();
        send_byte({dev, 1'b0}, exp_ack, tag, ok);
        if (ok) begin
            send_byte(addr[15:8], 1'b1, tag, ok);
            send_byte(addr[7:0], 1'b1, tag, ok);
            send_byte(data, 1'b1, tag, ok);
        end
        bus_stop();
    endtask

    task automatic eep_read(input logic [6:0] dev, input logic [15:0] addr, input logic [7:0] exp,
                            input logic exp_ack, input string tag);
        logic ok;
        bus_start();
        send_byte({dev, 1'b0}, exp_ack, tag, ok);
        if (ok) begin
            send_byte(addr[15:8], 1'b1, tag, ok);
            send_byte(addr[7:0], 1'b1, tag, ok);
            bus_start();
            send_byte({dev, 1'b1}, 1'b1, tag, ok);
            recv_byte(exp, tag);
        end
        bus_stop();
    endtask

    task automatic cycle_wait();
        repeat (WR_CYC + 200) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic ok;
        repeat (10) @(negedge clk);
        checks++;
        if (sda_oe !== 1'b0) begin
            errors++;
            $display("FAIL R1: got %0b expected 0", sda_oe);
        end
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        checks++;
        if (sda_oe !== 1'b0) begin
            errors++;
            $display("FAIL R1: got %0b expected 0", sda_oe);
        end

        // R3 R9: basic write, every byte acknowledged
        eep_write(7'h50, 16'h0123, 8'hA5, 1'b1, "R3_R9_write");
        // R6: immediate access is refused
        eep_read(7'h50, 16'h0123, 8'h00, 1'b0, "R6_busy_nack");
        cycle_wait();
        // R5: random read
        eep_read(7'h50, 16'h0123, 8'hA5, 1'b1, "R5_read");
        // R2: foreign addresses
        eep_read(7'h51, 16'h0123, 8'h00, 1'b0, "R2_strap_mismatch");
        eep_read(7'h48, 16'h0123, 8'h00, 1'b0, "R2_type_mismatch");
        // R4: upper address bits ignored
        eep_write(7'h50, 16'hE123, 8'h3C, 1'b1, "R4_write");
        cycle_wait();
        eep_read(7'h50, 16'h0123, 8'h3C, 1'b1, "R4_read");
        // R3: neighbouring byte in the same storage word kept
        eep_write(7'h50, 16'h0122, 8'h77, 1'b1, "R3_lane_write");
        cycle_wait();
        eep_read(7'h50, 16'h0123, 8'h3C, 1'b1, "R3_lane_keep");
        eep_read(7'h50, 16'h0122, 8'h77, 1'b1, "R3_lane_read");
        eep_write(7'h50, 16'h1FFF, 8'hC9, 1'b1, "R3_top_write");
        cycle_wait();
        eep_read(7'h50, 16'h1FFF, 8'hC9, 1'b1, "R3_top_read");
        // R9: second data byte in a write is not acknowledged
        bus_start();
        send_byte(8'hA0, 1'b1, "R9_extra", ok);
        send_byte(8'h00, 1'b1, "R9_extra", ok);
        send_byte(8'h40, 1'b1, "R9_extra", ok);
        send_byte(8'h5A, 1'b1, "R9_extra", ok);
        send_byte(8'h6B, 1'b0, "R9_extra_nack", ok);
        bus_stop();
        cycle_wait();
        eep_read(7'h50, 16'h0040, 8'h5A, 1'b1, "R9_extra_kept");
        // R7: address-only write leaves target ready and stores nothing
        bus_start();
        send_byte(8'hA0, 1'b1, "R7_addr_only", ok);
        send_byte(8'h00, 1'b1, "R7_addr_only", ok);
        send_byte(8'h40, 1'b1, "R7_addr_only", ok);
        bus_stop();
        eep_read(7'h50, 16'h0040, 8'h5A, 1'b1, "R7_no_busy");
        // R2: other strap setting
        strap = 3'b101;
        eep_write(7'h55, 16'h0AAA, 8'h96, 1'b1, "R2_strap_write");
        cycle_wait();
        eep_read(7'h50, 16'h0AAA, 8'h00, 1'b0, "R2_old_addr_nack");
        eep_read(7'h55, 16'h0AAA, 8'h96, 1'b1, "R2_strap_read");
        // R6: edges of the write cycle
        eep_write(7'h55, 16'h0555, 8'h1E, 1'b1, "R6_write");
        repeat (WR_CYC - 500) @(negedge clk);
        eep_read(7'h55, 16'h0555, 8'h00, 1'b0, "R6_late_nack");
        eep_read(7'h55, 16'h0555, 8'h1E, 1'b1, "R6_after_ack");

        repeat (20) @(negedge clk);
        checks++;
        if (r8_viol != 0) begin
            errors++;
            $display("FAIL R8: got %0d violations expected 0", r8_viol);
        end
        checks++;
        if (exp_q.size() != 0 || obs_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: got %0d left expected 0", exp_q.size() + obs_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule